// File: doc/BRIEF.md
# Removable Media Presence Status Tracker

This block follows the presence input of a removable drive and turns it into the sense status that the command logic returns to the host. The input is first brought into the clock domain by a two-stage synchronizer, then corrected for the configured pin polarity, and then debounced. A change is accepted only after the corrected level has held steady for a set number of clock cycles.

A small state machine with three states follows the debounced level. ST_PRESENT means media is in place and there is nothing to report. ST_ABSENT means media is missing, and a "no media" sense pair (0x3A/0x00) is reported for as long as that lasts. ST_CHANGED means media came back after an absence, and a "media changed" pair (0x28/0x00) is held until the command logic pulses its consume strobe. The transitions are: T_REMOVE (ST_PRESENT to ST_ABSENT on debounced absence), T_INSERT (ST_ABSENT to ST_CHANGED on debounced presence), T_REMOVE_AGAIN (ST_CHANGED to ST_ABSENT on debounced absence), T_CONSUME (ST_CHANGED to ST_PRESENT on the strobe) and T_DISABLE (any state to ST_PRESENT while detection is off). When detection is off, media is always reported present and no sense pair is pending.

Top module: `media_sense_tracker`

## Requirements
- R1: After reset, media_present is 1, sense_valid is 0, and sense_asc and sense_ascq are both 0x00. No "changed" report follows power-up.
- R2: When pin_low_present is 0, a high presence_pin means media is present. When pin_low_present is 1, a low presence_pin means media is present.
- R3: A change in the polarity-corrected presence level is recognized only after it has held for DEBOUNCE_CYCLES consecutive clocks. A shorter pulse leaves the outputs unchanged.
- R4: While media is absent (ST_ABSENT), media_present is 0, sense_valid is 1, sense_asc is 0x3A and sense_ascq is 0x00. This persists while media stays absent, and sense_consumed has no effect on it.
- R5: When media is recognized again after an absence (ST_CHANGED), media_present is 1, sense_valid is 1, sense_asc is 0x28 and sense_ascq is 0x00.
- R6: The "media changed" pair stays pending for any number of cycles without a strobe. A one-cycle sense_consumed pulse clears it to sense_valid 0 with codes 0x00.
- R7: A removal recognized while "media changed" is pending replaces it with the "no media" pair.
- R8: While detect_en is 0, media_present is 1 and sense_valid is 0 whatever the pin does, and any pending status is dropped. Re-enabling detection with media present reports nothing.
- R9: sense_consumed while nothing is pending leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presence_pin | input | 1 | Raw media-present pin, asynchronous |
| detect_en | input | 1 | 1 enables presence detection |
| pin_low_present | input | 1 | Polarity select: 1 means a low pin level signals media present |
| sense_consumed | input | 1 | One-cycle strobe: the pending sense pair has been reported |
| media_present | output | 1 | Media is currently treated as present |
| sense_valid | output | 1 | A sense pair is pending |
| sense_asc | output | 8 | Pending additional sense code |
| sense_ascq | output | 8 | Pending additional sense code qualifier |

## Verification
The pin is driven through full remove and reinsert cycles under both polarity settings. This shows whether the polarity select inverts the meaning of the pin and whether the absent and changed pairs are told apart. A pulse shorter than the debounce window is compared against a long level change, which separates filtering from plain synchronization. Strobes are given in every state: in the changed state, in the absent state and with nothing pending. A second removal during a pending change, and disabling detection while absent, check that the correct status takes over and that a pending status is dropped.

// File: rtl/media_sense_pkg.sv
package media_sense_pkg;

    typedef enum logic [1:0] {
        ST_PRESENT = 2'd0,
        ST_ABSENT  = 2'd1,
        ST_CHANGED = 2'd2
    } media_state_e;

    localparam logic [7:0] ASC_NO_MEDIA = 8'h3A;
    localparam logic [7:0] ASC_CHANGED  = 8'h28;
    localparam logic [7:0] ASCQ_ZERO    = 8'h00;

endpackage

// File: rtl/media_pin_sync.sv
module media_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic pin_low_present,
    output logic raw_present
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_async};
    end

    assign raw_present = pin_low_present ? ~chain[STAGES-1] : chain[STAGES-1];
endmodule

// File: rtl/media_debounce.sv
module media_debounce #(
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_present,
    output logic filt_present
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            filt_present <= 1'b1;
        end else if (raw_present == filt_present) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt          <= '0;
            filt_present <= raw_present;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: the filtered level moves only at the end of a full stable window
    p_filter_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_present) |-> $past(cnt) == CNT_LAST);
endmodule

// File: rtl/media_state_fsm.sv
module media_state_fsm
    import media_sense_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       detect_en,
    input  logic       filt_present,
    input  logic       consume,
    output logic       media_present,
    output logic       sense_valid,
    output logic [7:0] sense_asc,
    output logic [7:0] sense_ascq
);
    media_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (!detect_en) begin
            state_nx = ST_PRESENT;
        end else begin
            unique case (state)
                ST_PRESENT: if (!filt_present) state_nx = ST_ABSENT;
                ST_ABSENT:  if (filt_present)  state_nx = ST_CHANGED;
                ST_CHANGED: begin
                    if (!filt_present) state_nx = ST_ABSENT;
                    else if (consume)  state_nx = ST_PRESENT;
                end
                default:               state_nx = ST_PRESENT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRESENT;
        else        state <= state_nx;
    end

    always_comb begin
        media_present = 1'b1;
        sense_valid   = 1'b0;
        sense_asc     = ASCQ_ZERO;
        sense_ascq    = ASCQ_ZERO;
        unique case (state)
            ST_ABSENT: begin
                media_present = 1'b0;
                sense_valid   = 1'b1;
                sense_asc     = ASC_NO_MEDIA;
            end
            ST_CHANGED: begin
                sense_valid = 1'b1;
                sense_asc   = ASC_CHANGED;
            end
            default: ;
        endcase
    end

    // R5: the changed state is entered only from the absent state
    p_changed_from_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_CHANGED) |-> $past(state) == ST_ABSENT);

    // R6: without a strobe or a removal, the changed status is held
    p_changed_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHANGED && detect_en && filt_present && !consume)
        |=> state == ST_CHANGED);

    // R8: detection off forces the present state
    p_disabled_present_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !detect_en |=> state == ST_PRESENT);

    // R4: the absent state leaves only once the filtered level shows media
    p_absent_persists_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABSENT && detect_en && !filt_present) |=> state == ST_ABSENT);
endmodule

// File: rtl/media_sense_tracker.sv
module media_sense_tracker #(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presence_pin,
    input  logic       detect_en,
    input  logic       pin_low_present,
    input  logic       sense_consumed,
    output logic       media_present,
    output logic       sense_valid,
    output logic [7:0] sense_asc,
    output logic [7:0] sense_ascq
);
    logic raw_present;
    logic filt_present;

    media_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk             (clk),
        .rst_n           (rst_n),
        .pin_async       (presence_pin),
        .pin_low_present (pin_low_present),
        .raw_present     (raw_present)
    );

    media_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_present  (raw_present),
        .filt_present (filt_present)
    );

    media_state_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .detect_en     (detect_en),
        .filt_present  (filt_present),
        .consume       (sense_consumed),
        .media_present (media_present),
        .sense_valid   (sense_valid),
        .sense_asc     (sense_asc),
        .sense_ascq    (sense_ascq)
    );

    // R1: codes are zero whenever nothing is pending
    p_idle_codes_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_valid |-> (sense_asc == 8'h00 && sense_ascq == 8'h00 && media_present));
endmodule

// File: tb/media_sense_tracker_test.sv
module media_sense_tracker_test;
    localparam int DEB = 8;
    localparam int SETTLE = DEB + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic presence_pin = 1'b1;
    logic detect_en = 1'b1;
    logic pin_low_present = 1'b0;
    logic sense_consumed = 1'b0;
    logic media_present, sense_valid;
    logic [7:0] sense_asc, sense_ascq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    media_sense_tracker #(.DEBOUNCE_CYCLES(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .presence_pin(presence_pin),
        .detect_en(detect_en), .pin_low_present(pin_low_present),
        .sense_consumed(sense_consumed), .media_present(media_present),
        .sense_valid(sense_valid), .sense_asc(sense_asc), .sense_ascq(sense_ascq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic expect_out(string req, logic mp, logic sv, logic [7:0] asc);
        chk({req, " media_present"}, {7'd0, media_present}, {7'd0, mp});
        chk({req, " sense_valid"}, {7'd0, sense_valid}, {7'd0, sv});
        chk({req, " asc"}, sense_asc, asc);
        chk({req, " ascq"}, sense_ascq, 8'h00);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_media(bit present);
        presence_pin = present ^ pin_low_present;
    endtask

    task automatic consume_pulse();
        sense_consumed = 1'b1;
        cycles(1);
        sense_consumed = 1'b0;
        cycles(1);
    endtask

    task automatic t_reset();
        expect_out("R1 reset", 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_remove_reinsert();
        set_media(1'b0); cycles(SETTLE);
        expect_out("R4 absent", 1'b0, 1'b1, 8'h3A);
        consume_pulse();
        expect_out("R4 strobe ignored", 1'b0, 1'b1, 8'h3A);
        cycles(30);
        expect_out("R4 persists", 1'b0, 1'b1, 8'h3A);
        set_media(1'b1); cycles(SETTLE);
        expect_out("R5 changed", 1'b1, 1'b1, 8'h28);
        cycles(40);
        expect_out("R6 held", 1'b1, 1'b1, 8'h28);
        consume_pulse();
        expect_out("R6 cleared", 1'b1, 1'b0, 8'h00);
        consume_pulse();
        expect_out("R9 idle strobe", 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_glitch();
        set_media(1'b0); cycles(DEB - 4); set_media(1'b1);
        cycles(SETTLE);
        expect_out("R3 short pulse", 1'b1, 1'b0, 8'h00);
        set_media(1'b0); cycles(2 + DEB - 2);
        expect_out("R3 before window", 1'b1, 1'b0, 8'h00);
        cycles(4);
        expect_out("R3 after window", 1'b0, 1'b1, 8'h3A);
        set_media(1'b1); cycles(SETTLE);
        consume_pulse();
    endtask

    task automatic t_polarity();
        pin_low_present = 1'b1; presence_pin = 1'b0; cycles(SETTLE);
        expect_out("R2 low means present", 1'b1, 1'b0, 8'h00);
        presence_pin = 1'b1; cycles(SETTLE);
        expect_out("R2 high means absent", 1'b0, 1'b1, 8'h3A);
        presence_pin = 1'b0; cycles(SETTLE);
        expect_out("R2 back present", 1'b1, 1'b1, 8'h28);
        consume_pulse();
        pin_low_present = 1'b0; presence_pin = 1'b1; cycles(SETTLE);
        expect_out("R2 restored", 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_remove_during_changed();
        set_media(1'b0); cycles(SETTLE);
        set_media(1'b1); cycles(SETTLE);
        expect_out("R7 changed first", 1'b1, 1'b1, 8'h28);
        set_media(1'b0); cycles(SETTLE);
        expect_out("R7 absent wins", 1'b0, 1'b1, 8'h3A);
        set_media(1'b1); cycles(SETTLE);
        consume_pulse();
    endtask

    task automatic t_disable();
        set_media(1'b0); cycles(SETTLE);
        detect_en = 1'b0; cycles(2);
        expect_out("R8 disabled while absent", 1'b1, 1'b0, 8'h00);
        set_media(1'b1); cycles(SETTLE);
        set_media(1'b0); cycles(SETTLE);
        expect_out("R8 pin ignored", 1'b1, 1'b0, 8'h00);
        set_media(1'b1); cycles(SETTLE);
        detect_en = 1'b1; cycles(SETTLE);
        expect_out("R8 reenable present", 1'b1, 1'b0, 8'h00);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(SETTLE);
        t_reset();
        t_remove_reinsert();
        t_glitch();
        t_polarity();
        t_remove_during_changed();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule